// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a set of level-sensitive interrupt request lines and picks one winner to present to a processor. The processor gets the winner as two registered values: an interrupt level and a vector number. Software reaches the block through a small synchronous register bus. The bus has an 8-bit byte offset, separate read and write strobes, and 32-bit data.

Each source has its own programmable level byte, and a level of zero also switches the source off. A global mask can be written as two 32-bit halves. It can also be changed one bit at a time with set and clear commands, and each of those commands has an option that acts on every source at once. Software can read the pending inputs, the mask and the level bytes. Reading the vector register acts as the software acknowledge path.

The winner is the active source with the largest level. When two sources have the same level, the one with the higher index wins. When nothing is active, a fixed spurious vector is shown.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the mask is all ones. Pending, enable and every level byte are zero. `irq_lvl` reads 0, and both `irq_vec` and a read of offset 0xE0 return 24.
- R2: On every clock, the pending register captures `irq_in`, and it also captures it during reset release. Offset 0x00 reads pending bits 63:32 and offset 0x04 reads bits 31:0. Writes to 0x00 and 0x04 change nothing.
- R3: Writing offset 0x40+n stores `bus_wdata[7:0]` as the level of source n. The same offset reads it back, zero-extended. A zero level clears the enable of source n, and any nonzero level sets it.
- R4: Writing 0x08 replaces mask bits 63:32 and writing 0x0C replaces mask bits 31:0. In each case the other half is left as it was. Both offsets read back their half.
- R5: A write to 0x1C sets the mask bit selected by `bus_wdata[5:0]`. If `bus_wdata[6]` is 1, it sets all 64 mask bits instead.
- R6: A write to 0x1D clears the mask bit selected by `bus_wdata[5:0]`. If `bus_wdata[6]` is 1, it clears all 64 mask bits instead.
- R7: A source is active when its pending bit is 1, its enable is 1 and its mask bit is 0. The winner is the active source with the largest level byte.
- R8: When active sources share the largest level, the source with the highest index wins.
- R9: `irq_vec` is 64 plus the winner's index, and `irq_lvl` is the winner's level. With no active source they are 0 and 24. Both outputs are registered: they follow the controller state one clock after that state changes.
- R10: Offsets 0x10 and 0x14 (the force register, which has no write path) read zero. Offset 0xE0 reads the current vector, and every other unmapped offset reads zero. Read data appears on the clock edge that samples `bus_rd`, and it holds until the next read.
- R11: A write to any offset that is not listed in R2 to R6 leaves the mask, the enables and the level bytes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 64 | Level-sensitive interrupt requests |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_lvl | output | 8 | Level of the winning source, or 0 when there is none |
| irq_vec | output | 8 | Vector of the winning source, or 24 when there is none |

## Verification
The bench builds the block with its default parameters: 64 sources, 8-bit levels, vector base 64 and spurious vector 24. With these values the whole register map is reachable, including both mask halves and the top source, index 63, with vector 127. The bench uses level 0x80 on source 63 to show that the level comparison is unsigned. It also arranges equal levels on two sources to exercise the tie rule. It checks the one-cycle output latency by sampling the outputs on the edge right after a write and again on the edge after that.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam logic [7:0] OFF_PEND_HI = 8'h00;
  localparam logic [7:0] OFF_PEND_LO = 8'h04;
  localparam logic [7:0] OFF_MASK_HI = 8'h08;
  localparam logic [7:0] OFF_MASK_LO = 8'h0C;
  localparam logic [7:0] OFF_FRC_HI  = 8'h10;
  localparam logic [7:0] OFF_FRC_LO  = 8'h14;
  localparam logic [7:0] OFF_MSET    = 8'h1C;
  localparam logic [7:0] OFF_MCLR    = 8'h1D;
  localparam logic [7:0] OFF_VEC     = 8'hE0;
  localparam logic [1:0] LVL_PAGE    = 2'b01;  // offsets 0x40..0x7F
  localparam int         ALL_BIT     = 6;

  typedef enum logic [2:0] {
    WR_NONE, WR_MASK_HI, WR_MASK_LO, WR_MSET, WR_MCLR, WR_LEVEL
  } wr_kind_e;

  function automatic wr_kind_e decode_wr(input logic [7:0] a);
    if (a[7:6] == LVL_PAGE) return WR_LEVEL;
    case (a)
      OFF_MASK_HI: return WR_MASK_HI;
      OFF_MASK_LO: return WR_MASK_LO;
      OFF_MSET:    return WR_MSET;
      OFF_MCLR:    return WR_MCLR;
      default:     return WR_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 8,
  parameter int DATA_W  = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_SRC-1:0]              irq_in,
  input  logic [7:0]                      bus_addr,
  input  logic                            bus_wr,
  input  logic [DATA_W-1:0]               bus_wdata,
  output logic [NUM_SRC-1:0]              pend_q,
  output logic [NUM_SRC-1:0]              mask_q,
  output logic [NUM_SRC-1:0]              en_q,
  output logic [NUM_SRC-1:0][LVL_W-1:0]   lvl_q
);
  wr_kind_e         kind;
  logic [IDX_W-1:0] sel;
  logic             all_cmd;

  assign kind    = bus_wr ? decode_wr(bus_addr) : WR_NONE;
  assign sel     = bus_wdata[IDX_W-1:0];
  assign all_cmd = bus_wdata[ALL_BIT];

  // pending simply samples the request lines
  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= irq_in;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
    end else begin
      case (kind)
        WR_MASK_HI: mask_q[NUM_SRC-1:DATA_W] <= bus_wdata[NUM_SRC-DATA_W-1:0];
        WR_MASK_LO: mask_q[DATA_W-1:0]       <= bus_wdata;
        WR_MSET:    if (all_cmd) mask_q <= '1; else mask_q[sel] <= 1'b1;
        WR_MCLR:    if (all_cmd) mask_q <= '0; else mask_q[sel] <= 1'b0;
        default: ;
      endcase
    end
  end

  // one level byte and enable per source
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    always_ff @(posedge clk) begin
      if (rst) begin
        lvl_q[i] <= '0;
        en_q[i]  <= 1'b0;
      end else if (kind == WR_LEVEL && bus_addr[IDX_W-1:0] == IDX_W'(i)) begin
        lvl_q[i] <= bus_wdata[LVL_W-1:0];
        en_q[i]  <= |bus_wdata[LVL_W-1:0];
      end
    end
  end

  AST_PEND_TRACKS: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pend_q == $past(irq_in)); // R2
  AST_LVL_ZERO_OFF: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[7:6] == LVL_PAGE && bus_wdata[LVL_W-1:0] == '0)
    |=> !en_q[$past(bus_addr[IDX_W-1:0])]); // R3
  AST_MASK_ALL_SET: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_MSET && bus_wdata[ALL_BIT]) |=> &mask_q); // R5
  AST_MASK_ALL_CLR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFF_MCLR && bus_wdata[ALL_BIT]) |=> mask_q == '0); // R6
  AST_UNDEF_WR_NOP: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[7:6] != LVL_PAGE && bus_addr != OFF_MASK_HI &&
     bus_addr != OFF_MASK_LO && bus_addr != OFF_MSET && bus_addr != OFF_MCLR)
    |=> $stable(mask_q) && $stable(en_q) && $stable(lvl_q)); // R11
endmodule

// File: rtl/irq_arb_tree.sv
module irq_arb_tree #(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 8,
  localparam int IDX_W  = $clog2(NUM_SRC),
  localparam int NODES  = 2 * NUM_SRC
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SRC-1:0]            active,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
  output logic                          win_v,
  output logic [LVL_W-1:0]              win_lvl,
  output logic [IDX_W-1:0]              win_idx
);
  // heap layout: node 1 is the root, node NUM_SRC+i is leaf i
  logic             node_v [1:NODES-1];
  logic [LVL_W-1:0] node_l [1:NODES-1];
  logic [IDX_W-1:0] node_x [1:NODES-1];

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_leaf
    assign node_v[NUM_SRC+i] = active[i];
    assign node_l[NUM_SRC+i] = lvl[i];
    assign node_x[NUM_SRC+i] = IDX_W'(i);
  end

  // child 2k holds lower indices, child 2k+1 higher; ties go to the higher side
  for (genvar k = 1; k < NUM_SRC; k++) begin : g_node
    logic take_hi;
    assign take_hi   = node_v[2*k+1] && (!node_v[2*k] || node_l[2*k+1] >= node_l[2*k]);
    assign node_v[k] = node_v[2*k] | node_v[2*k+1];
    assign node_l[k] = take_hi ? node_l[2*k+1] : node_l[2*k];
    assign node_x[k] = take_hi ? node_x[2*k+1] : node_x[2*k];
  end

  assign win_v   = node_v[1];
  assign win_lvl = node_l[1];
  assign win_idx = node_x[1];

  AST_WIN_IS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    win_v |-> active[win_idx]); // R7
  AST_WIN_LVL_MATCH: assert property (@(posedge clk) disable iff (rst)
    win_v |-> win_lvl == lvl[win_idx]); // R7
endmodule

// File: rtl/irq_readback.sv
module irq_readback
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int LVL_W   = 8,
  parameter int DATA_W  = 32,
  parameter int VEC_W   = 8,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [7:0]                    bus_addr,
  input  logic                          bus_rd,
  input  logic [NUM_SRC-1:0]            pend_q,
  input  logic [NUM_SRC-1:0]            mask_q,
  input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q,
  input  logic [VEC_W-1:0]              vec_q,
  output logic [DATA_W-1:0]             bus_rdata
);
  localparam int HI_W = NUM_SRC - DATA_W;

  logic [NUM_SRC-1:0] force_q;  // no write path
  logic [DATA_W-1:0]  rd_mux;

  assign force_q = '0;

  always_comb begin
    rd_mux = '0;
    if (bus_addr[7:6] == LVL_PAGE) begin
      rd_mux = DATA_W'(lvl_q[bus_addr[IDX_W-1:0]]);
    end else begin
      case (bus_addr)
        OFF_PEND_HI: rd_mux = DATA_W'(pend_q[NUM_SRC-1 -: HI_W]);
        OFF_PEND_LO: rd_mux = pend_q[DATA_W-1:0];
        OFF_MASK_HI: rd_mux = DATA_W'(mask_q[NUM_SRC-1 -: HI_W]);
        OFF_MASK_LO: rd_mux = mask_q[DATA_W-1:0];
        OFF_FRC_HI:  rd_mux = DATA_W'(force_q[NUM_SRC-1 -: HI_W]);
        OFF_FRC_LO:  rd_mux = force_q[DATA_W-1:0];
        OFF_VEC:     rd_mux = DATA_W'(vec_q);
        default:     rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && (bus_addr == OFF_FRC_HI || bus_addr == OFF_FRC_LO)) |=> bus_rdata == '0); // R10
  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R10
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NUM_SRC  = 64,
  parameter int LVL_W    = 8,
  parameter int DATA_W   = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  parameter int SPUR_VEC = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_SRC-1:0]  irq_in,
  input  logic [7:0]          bus_addr,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [LVL_W-1:0]    irq_lvl,
  output logic [VEC_W-1:0]    irq_vec
);
  localparam int              IDX_W = $clog2(NUM_SRC);
  localparam logic [VEC_W-1:0] VB   = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] VS   = VEC_W'(SPUR_VEC);

  logic [NUM_SRC-1:0]            pend_q, mask_q, en_q, active;
  logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
  logic                          win_v;
  logic [LVL_W-1:0]              win_lvl;
  logic [IDX_W-1:0]              win_idx;

  irq_cfg_regs #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .pend_q(pend_q), .mask_q(mask_q), .en_q(en_q), .lvl_q(lvl_q));

  assign active = pend_q & en_q & ~mask_q;

  irq_arb_tree #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W)) i_arb (
    .clk(clk), .rst(rst), .active(active), .lvl(lvl_q),
    .win_v(win_v), .win_lvl(win_lvl), .win_idx(win_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_lvl <= '0;
      irq_vec <= VS;
    end else if (win_v) begin
      irq_lvl <= win_lvl;
      irq_vec <= VB + VEC_W'(win_idx);
    end else begin
      irq_lvl <= '0;
      irq_vec <= VS;
    end
  end

  irq_readback #(.NUM_SRC(NUM_SRC), .LVL_W(LVL_W), .DATA_W(DATA_W), .VEC_W(VEC_W)) i_rd (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .pend_q(pend_q),
    .mask_q(mask_q), .lvl_q(lvl_q), .vec_q(irq_vec), .bus_rdata(bus_rdata));

  AST_IDLE_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    (irq_lvl == '0) |-> (irq_vec == VS)); // R9
  AST_OUT_FOLLOWS_WIN: assert property (@(posedge clk) disable iff (rst)
    $past(win_v) |-> (irq_lvl == $past(win_lvl) && irq_vec == VB + VEC_W'($past(win_idx)))); // R9
endmodule

// File: tb/test_irq_prio_ctrl.sv
module test_irq_prio_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [63:0] irq_in = '0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  irq_lvl, irq_vec;
  int checks = 0, fails = 0;

  always #5 clk = ~clk;

  irq_prio_ctrl i_irq_prio_ctrl (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lvl(irq_lvl), .irq_vec(irq_vec));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic chk_out(input string req, input logic [7:0] l, input logic [7:0] v);
    chk({req, " lvl"}, 32'(irq_lvl), 32'(l));
    chk({req, " vec"}, 32'(irq_vec), 32'(v));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk_out("R1 reset", 8'd0, 8'd24);
    rd(8'h08, d); chk("R1 mask hi", d, 32'hFFFF_FFFF);
    rd(8'h0C, d); chk("R1 mask lo", d, 32'hFFFF_FFFF);
    rd(8'h04, d); chk("R1 pend lo", d, 32'h0);
    rd(8'h45, d); chk("R1 level5", d, 32'h0);
    rd(8'hE0, d); chk("R1 vec read", d, 32'd24);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    @(negedge clk); irq_in = 64'hDEAD_BEEF_0123_4567;
    tick(); tick();
    rd(8'h00, d); chk("R2 pend hi", d, 32'hDEAD_BEEF);
    rd(8'h04, d); chk("R2 pend lo", d, 32'h0123_4567);
    wr(8'h04, 32'h0); wr(8'h00, 32'h0);
    rd(8'h04, d); chk("R2 pend write ignored", d, 32'h0123_4567);
    chk_out("R7 all masked", 8'd0, 8'd24);
    @(negedge clk); irq_in = '0;
  endtask

  task automatic t_levels();
    logic [31:0] d;
    wr(8'h45, 32'hFFFF_FF03);
    rd(8'h45, d); chk("R3 level5 readback", d, 32'h03);
  endtask

  task automatic t_mask_words();
    logic [31:0] d;
    wr(8'h08, 32'hA5A5_0000);
    rd(8'h08, d); chk("R4 mask hi", d, 32'hA5A5_0000);
    rd(8'h0C, d); chk("R4 lo kept", d, 32'hFFFF_FFFF);
    wr(8'h0C, 32'h1234_5678);
    rd(8'h0C, d); chk("R4 mask lo", d, 32'h1234_5678);
    rd(8'h08, d); chk("R4 hi kept", d, 32'hA5A5_0000);
  endtask

  task automatic t_setclr();
    logic [31:0] d;
    wr(8'h1D, 32'h40);
    rd(8'h08, d); chk("R6 clear all hi", d, 32'h0);
    wr(8'h1C, 32'h07);
    rd(8'h0C, d); chk("R5 set bit7", d, 32'h80);
    wr(8'h1C, 32'h40);
    rd(8'h0C, d); chk("R5 set all", d, 32'hFFFF_FFFF);
    wr(8'h1D, 32'h25);
    rd(8'h08, d); chk("R6 clear bit37", d, 32'hFFFF_FFDF);
    rd(8'h0C, d); chk("R6 lo untouched", d, 32'hFFFF_FFFF);
  endtask

  task automatic t_arb();
    logic [31:0] d;
    wr(8'h1D, 32'h40);
    wr(8'h4A, 32'd3);  // source 10 level 3 (source 5 already 3)
    wr(8'h68, 32'd7);  // source 40 level 7
    @(negedge clk); irq_in = (64'd1 << 5) | (64'd1 << 10) | (64'd1 << 40);
    tick(); tick();
    chk_out("R7 highest level", 8'd7, 8'd104);
    wr(8'h1C, 32'd40);
    chk_out("R9 latency old value", 8'd7, 8'd104);
    tick();
    chk_out("R8 tie high index", 8'd3, 8'd74);
    wr(8'h4A, 32'd0);
    tick();
    chk_out("R3 zero disables", 8'd3, 8'd69);
    @(negedge clk); irq_in[63] = 1'b1;
    wr(8'h7F, 32'h80);
    tick();
    chk_out("R7 unsigned top", 8'h80, 8'd127);
    rd(8'hE0, d); chk("R10 vec read", d, 32'd127);
    @(negedge clk); irq_in = '0;
    tick(); tick();
    chk_out("R9 idle", 8'd0, 8'd24);
  endtask

  task automatic t_undef();
    logic [31:0] d;
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R11 mask hi kept", d, 32'h0000_0100);
    rd(8'h0C, d); chk("R11 mask lo kept", d, 32'h0);
    rd(8'h68, d); chk("R11 level40 kept", d, 32'd7);
    rd(8'h10, d); chk("R10 force hi", d, 32'h0);
    rd(8'h14, d); chk("R10 force lo", d, 32'h0);
    rd(8'h20, d); chk("R10 unmapped", d, 32'h0);
    @(negedge clk); irq_in = 64'd1 << 5;
    tick(); tick();
    chk_out("R11 enables kept", 8'd3, 8'd69);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    tick();
    t_reset();
    t_pending();
    t_levels();
    t_mask_words();
    t_setclr();
    t_arb();
    t_undef();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired got=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule